// File: doc/BRIEF.md
# Single-Buffer Frame Transmit Launcher

This block is the transmit control path of a simple Ethernet MAC that handles one frame buffer at a time. Software programs a buffer address and then writes a byte count. Writing a nonzero count starts the frame. The block fetches the buffer from memory in 32-bit words over a request/acknowledge read port. It presents the bytes on a byte-wide valid/ready stream toward the MAC transmitter and marks the final byte.

The byte count register also serves as the live remaining-byte counter. It falls by one for every byte the MAC accepts, so software can poll it until it reads zero to learn that the frame is finished. A status word reports whether a new buffer may be programmed, and carries a sticky frame-done flag that software clears by writing a one to it. A control word holds separate transmit and receive enables. Clearing the transmit enable aborts a frame in flight. Preamble, CRC and collision back-off are handled elsewhere.

Top module: `tx_launcher`

## Requirements
- R1: After reset, the control word (reg_sel 0), the address (reg_sel 2) and the length (reg_sel 3) read as zero. The status word (reg_sel 1) reads 1. tx_valid, mem_req and rx_en are low.
- R2: With transmit enabled and the length at zero, a write of a nonzero value N to length bits [10:0] (reg_sel 3) launches a frame. Exactly N bytes then appear on the stream, and tx_last is high on the N-th byte only.
- R3: The address register keeps bits [31:2], and bits [1:0] read as zero. The frame is fetched as consecutive 32-bit words starting at that word address. mem_req stays high with a stable mem_addr until mem_ack.
- R4: Within each fetched word, bits [7:0] are sent first, then [15:8], [23:16] and [31:24].
- R5: The length register reads the number of bytes not yet accepted. It drops by one on each accepted byte and reads zero once the frame is done. Status bit 0 reads 1 exactly when the length is zero.
- R6: Status bit 1 (frame done) is set in the cycle after the last byte is accepted. A write to reg_sel 1 with bit 1 set clears it, and a write with bit 1 clear leaves it set.
- R7: Writing zero to the length register starts no frame: no memory request is made, the length stays zero and the done flag does not change.
- R8: While the length is nonzero, writes to the address or length registers are ignored.
- R9: Control bit 0 is the transmit enable. A length write while it is clear is ignored. Clearing it during a frame drops the length to zero, stops the stream and the fetch, and does not set the done flag.
- R10: Control bit 1 is the receive enable. It drives rx_en and reads back in the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 address, 3 length |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word (word aligned) |
| mem_ack | input | 1 | Read acknowledge; mem_rdata valid in this cycle |
| mem_rdata | input | 32 | Read word |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | MAC accepts the byte this cycle |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Current byte is the final byte of the frame |
| rx_en | output | 1 | Receive enable from the control word |

## Verification
The properties assume a well-behaved memory port. mem_ack is raised only while mem_req is high, and mem_rdata carries the addressed word in that same cycle. They also assume that register writes last exactly one cycle. The stimulus meets this by computing mem_ack from the current mem_req at the falling edge and looking up mem_rdata from the current mem_addr at the same moment. Writes are issued as single-cycle strobes between rising edges. tx_ready and the acknowledge latency follow several fixed patterns, including stalls and back-to-back acceptance, so that word boundaries fall on both stalled and free-running bytes.

// File: rtl/txl_pkg.sv
package txl_pkg;

    parameter int unsigned WORD_W = 32;
    parameter int unsigned ADDR_W = 32;
    parameter int unsigned LEN_W  = 11;

    localparam int unsigned BYTES = WORD_W / 8;
    localparam int unsigned IDX_W = $clog2(BYTES);

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_LEN  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_SEND  = 2'd2
    } seq_state_e;

    // Byte lane i of a word, lane 0 being bits [7:0].
    function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                             input logic [IDX_W-1:0]  i);
        return w[8*i +: 8];
    endfunction

endpackage

// File: rtl/txl_regs.sv
module txl_regs
    import txl_pkg::*;
#(
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_LEN_W  = LEN_W,
    parameter int unsigned P_OFS    = IDX_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [1:0]                 sel,
    input  logic [P_ADDR_W-1:0]        wdata,
    output logic [P_ADDR_W-1:0]        rdata,
    input  logic                       fire,
    output ctrl_t                      ctrl_o,
    output logic [P_LEN_W-1:0]         len_o,
    output logic [P_ADDR_W-P_OFS-1:0]  ptr_o,
    output logic                       done_o,
    output logic                       start_o,
    output logic                       halt_o
);

    ctrl_t                      ctrl_q;
    logic [P_LEN_W-1:0]         len_q;
    logic [P_ADDR_W-P_OFS-1:0]  ptr_q;
    logic                       done_q;
    logic                       busy;
    logic                       wr_ctrl, wr_stat, wr_addr, wr_len;
    logic                       finish;

    always_comb begin
        wr_ctrl = wr_en && (sel == SEL_CTRL);
        wr_stat = wr_en && (sel == SEL_STAT);
        wr_addr = wr_en && (sel == SEL_ADDR);
        wr_len  = wr_en && (sel == SEL_LEN);
        busy    = (len_q != '0);
        halt_o  = wr_ctrl && !wdata[0];
        start_o = wr_len && !busy && ctrl_q.tx_en && (wdata[P_LEN_W-1:0] != '0);
        finish  = fire && (len_q == P_LEN_W'(1)) && !halt_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ptr_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.rx_en <= wdata[1];
                ctrl_q.tx_en <= wdata[0];
            end
            if (wr_addr && !busy) begin
                ptr_q <= wdata[P_ADDR_W-1:P_OFS];
            end
            if (halt_o) begin
                len_q <= '0;
            end else if (start_o) begin
                len_q <= wdata[P_LEN_W-1:0];
            end else if (fire && busy) begin
                len_q <= len_q - P_LEN_W'(1);
            end
            done_q <= finish || (done_q && !(wr_stat && wdata[1]));
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: rdata[1:0] = {ctrl_q.rx_en, ctrl_q.tx_en};
            SEL_STAT: rdata[1:0] = {done_q, !busy};
            SEL_ADDR: rdata[P_ADDR_W-1:P_OFS] = ptr_q;
            default:  rdata[P_LEN_W-1:0] = len_q;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign len_o  = len_q;
    assign ptr_o  = ptr_q;
    assign done_o = done_q;

endmodule

// File: rtl/txl_seq.sv
module txl_seq
    import txl_pkg::*;
#(
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_WORD_W = WORD_W,
    parameter int unsigned P_LEN_W  = LEN_W,
    parameter int unsigned P_OFS    = IDX_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       abort,
    input  logic [P_ADDR_W-P_OFS-1:0]  start_ptr,
    input  logic [P_LEN_W-1:0]         remaining,
    output logic                       mem_req,
    output logic [P_ADDR_W-1:0]        mem_addr,
    input  logic                       mem_ack,
    input  logic [P_WORD_W-1:0]        mem_rdata,
    output logic                       tx_valid,
    input  logic                       tx_ready,
    output logic [7:0]                 tx_data,
    output logic                       fire
);

    localparam logic [P_OFS-1:0] LAST_LANE = P_OFS'(P_WORD_W/8 - 1);

    seq_state_e                 state_q;
    logic [P_ADDR_W-P_OFS-1:0]  wptr_q;
    logic [P_WORD_W-1:0]        word_q;
    logic [P_OFS-1:0]           lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            wptr_q  <= '0;
            word_q  <= '0;
            lane_q  <= '0;
        end else if (abort) begin
            state_q <= SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        wptr_q  <= start_ptr;
                        lane_q  <= '0;
                        state_q <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    if (mem_ack) begin
                        word_q  <= mem_rdata;
                        state_q <= SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (tx_ready) begin
                        if (remaining == P_LEN_W'(1)) begin
                            state_q <= SQ_IDLE;
                        end else if (lane_q == LAST_LANE) begin
                            lane_q  <= '0;
                            wptr_q  <= wptr_q + 1'b1;
                            state_q <= SQ_FETCH;
                        end else begin
                            lane_q <= lane_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = (state_q == SQ_FETCH);
        mem_addr = {wptr_q, {P_OFS{1'b0}}};
        tx_valid = (state_q == SQ_SEND);
        tx_data  = pick_byte(word_q, lane_q);
        fire     = tx_valid && tx_ready;
    end

endmodule

// File: rtl/tx_launcher.sv
module tx_launcher
    import txl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [1:0]           reg_sel,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_data,
    output logic                 tx_last,
    output logic                 rx_en
);

    ctrl_t                      ctrl_w;
    logic [LEN_W-1:0]           len_q;
    logic [ADDR_W-IDX_W-1:0]    buf_ptr;
    logic                       done_q;
    logic                       start_w;
    logic                       halt_w;
    logic                       fire_w;
    logic                       tx_en_w;

    txl_regs #(
        .P_ADDR_W (ADDR_W),
        .P_LEN_W  (LEN_W),
        .P_OFS    (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .fire    (fire_w),
        .ctrl_o  (ctrl_w),
        .len_o   (len_q),
        .ptr_o   (buf_ptr),
        .done_o  (done_q),
        .start_o (start_w),
        .halt_o  (halt_w)
    );

    txl_seq #(
        .P_ADDR_W (ADDR_W),
        .P_WORD_W (WORD_W),
        .P_LEN_W  (LEN_W),
        .P_OFS    (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .abort     (halt_w),
        .start_ptr (buf_ptr),
        .remaining (len_q),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .fire      (fire_w)
    );

    assign tx_en_w = ctrl_w.tx_en;
    assign rx_en   = ctrl_w.rx_en;
    assign tx_last = tx_valid && (len_q == LEN_W'(1));

endmodule

// File: rtl/txl_chk.sv
module txl_chk
    import txl_pkg::*;
#(
    parameter int unsigned C_ADDR_W = ADDR_W,
    parameter int unsigned C_LEN_W  = LEN_W,
    parameter int unsigned C_OFS    = IDX_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       reg_wr_en,
    input logic [1:0]                 reg_sel,
    input logic [C_LEN_W-1:0]         wdata_lo,
    input logic                       tx_valid,
    input logic                       tx_ready,
    input logic                       tx_last,
    input logic                       mem_req,
    input logic                       mem_ack,
    input logic [C_ADDR_W-1:0]        mem_addr,
    input logic [C_LEN_W-1:0]         len_cnt,
    input logic [C_ADDR_W-C_OFS-1:0]  ptr,
    input logic                       done,
    input logic                       tx_en
);

    logic halt_wr;
    logic acc;
    assign halt_wr = reg_wr_en && (reg_sel == 2'd0) && !wdata_lo[0];
    assign acc     = tx_valid && tx_ready;

    a_r2_valid_has_len: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (len_cnt != '0));

    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !halt_wr) |=> (mem_req && $stable(mem_addr)));

    a_r5_len_step: assert property (@(posedge clk) disable iff (rst)
        (acc && !halt_wr) |=> (len_cnt == $past(len_cnt) - C_LEN_W'(1)));

    a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (acc && tx_last && !halt_wr) |=> done);

    a_r7_zero_len_idle: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_sel == 2'd3 && wdata_lo == '0 && len_cnt == '0)
        |=> (len_cnt == '0 && !mem_req));

    a_r8_len_frozen: assert property (@(posedge clk) disable iff (rst)
        (len_cnt != '0 && !acc && !halt_wr) |=> $stable(len_cnt));

    a_r8_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (len_cnt != '0 && reg_wr_en && reg_sel == 2'd2) |=> $stable(ptr));

    a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> (!tx_valid && !mem_req));

endmodule

bind tx_launcher txl_chk #(
    .C_ADDR_W (txl_pkg::ADDR_W),
    .C_LEN_W  (txl_pkg::LEN_W),
    .C_OFS    (txl_pkg::IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .wdata_lo  (reg_wdata[txl_pkg::LEN_W-1:0]),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_last   (tx_last),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .len_cnt   (len_q),
    .ptr       (buf_ptr),
    .done      (done_q),
    .tx_en     (tx_en_w)
);

// File: tb/test_tx_launcher.sv
`timescale 1ns/1ps
module test_tx_launcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        rx_en;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit rdy_mode = 1'b0;
    logic [31:0] mem [0:63];
    logic [8:0]  exp_q [$];

    tx_launcher i_tx_launcher (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .rx_en(rx_en)
    );

    initial forever #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = s;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    // Driver: queue the expected bytes of a frame, then program it.
    task automatic launch(input logic [31:0] a, input int n);
        logic [31:0] base;
        base = a & 32'hFFFF_FFFC;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = mem[((base >> 2) + i / 4) & 63];
            exp_q.push_back({(i == n - 1), w[8*(i%4) +: 8]});
        end
        wr(2'd2, a);
        wr(2'd3, n);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        v = 32'hFFFF;
        for (int k = 0; k < 3000 && v != 0; k++) rd(2'd3, v);
        chk(v == 0, {tag, " length returns to zero"}, v, 0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " all bytes delivered"}, exp_q.size(), 0);
    endtask

    // Memory model and monitor: inputs set and outputs sampled at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready  = rdy_mode ? 1'b1 : ((cyc % 5) != 2);
            mem_ack   = mem_req && ((cyc % 3) != 1);
            mem_rdata = mem[mem_addr[7:2]];
            if (!rst && tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected byte", {24'd0, tx_data}, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk(tx_data == e[7:0], "R4 byte value/order", {24'd0, tx_data}, {24'd0, e[7:0]});
                    chk(tx_last == e[8], "R2 last flag", {31'd0, tx_last}, {31'd0, e[8]});
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2 actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++)
            mem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ 32'h5A3C_9600;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 control reset", v, 0);
        rd(2'd1, v); chk(v == 1, "R1 status reset", v, 1);
        rd(2'd2, v); chk(v == 0, "R1 address reset", v, 0);
        rd(2'd3, v); chk(v == 0, "R1 length reset", v, 0);
        chk(!tx_valid && !mem_req && !rx_en, "R1 outputs idle",
            {29'd0, tx_valid, mem_req, rx_en}, 0);

        // R9 launch ignored while transmit disabled
        wr(2'd3, 32'd5);
        rd(2'd3, v); chk(v == 0, "R9 length write ignored when disabled", v, 0);
        repeat (3) @(negedge clk);
        chk(!tx_valid && !mem_req, "R9 no activity when disabled", {30'd0, tx_valid, mem_req}, 0);

        // R10 receive enable
        wr(2'd0, 32'd3);
        rd(2'd0, v); chk(v == 3, "R10 control readback", v, 3);
        #1; chk(rx_en == 1'b1, "R10 rx_en output", {31'd0, rx_en}, 1);
        wr(2'd0, 32'd1);
        #1; chk(rx_en == 1'b0, "R10 rx_en cleared", {31'd0, rx_en}, 0);

        // R7 zero length
        wr(2'd3, 32'd0);
        repeat (3) @(negedge clk);
        chk(!mem_req && !tx_valid, "R7 no fetch on zero length", {30'd0, mem_req, tx_valid}, 0);
        rd(2'd1, v); chk(v == 1, "R7 status after zero length", v, 1);

        // R2 R6 single byte frame
        launch(32'h10, 1);
        wait_idle("R2 len1");
        rd(2'd1, v); chk(v == 3, "R6 done set, queue free", v, 3);
        wr(2'd1, 32'd0);
        rd(2'd1, v); chk(v == 3, "R6 write zero keeps done", v, 3);
        wr(2'd1, 32'd2);
        rd(2'd1, v); chk(v == 1, "R6 write one clears done", v, 1);

        // R2 R4 one full word
        launch(32'h20, 4);
        wait_idle("R4 len4");

        // R3 address low bits, word crossing
        wr(2'd2, 32'h33);
        rd(2'd2, v); chk(v == 32'h30, "R3 address low bits zero", v, 32'h30);
        launch(32'h33, 7);
        wait_idle("R3 len7");

        // R3 free-running stream
        rdy_mode = 1'b1;
        launch(32'h40, 13);
        wait_idle("R3 len13");
        rdy_mode = 1'b0;

        // R5 R8 frame in flight
        launch(32'h60, 30);
        rd(2'd3, v); chk(v != 0 && v <= 30, "R5 length nonzero while busy", v, 30);
        rd(2'd1, v); chk(v[0] == 1'b0, "R5 queue-free low while busy", v, 0);
        wr(2'd2, 32'h100);
        wr(2'd3, 32'd2000);
        rd(2'd2, v); chk(v == 32'h60, "R8 address write ignored", v, 32'h60);
        rd(2'd3, v); chk(v != 0 && v < 30, "R8 length write ignored", v, 30);
        wait_idle("R8 len30");
        rd(2'd1, v); chk(v == 3, "R5 queue free after frame", v, 3);
        wr(2'd1, 32'd2);

        // R9 halt mid-frame
        launch(32'h80, 60);
        repeat (20) @(negedge clk);
        wr(2'd0, 32'd0);
        rd(2'd3, v); chk(v == 0, "R9 halt clears length", v, 0);
        chk(!tx_valid && !mem_req, "R9 halt stops stream", {30'd0, tx_valid, mem_req}, 0);
        rd(2'd1, v); chk(v == 1, "R9 halt leaves done clear", v, 1);
        exp_q.delete();
        repeat (5) @(negedge clk);
        chk(!tx_valid, "R9 stream stays idle", {31'd0, tx_valid}, 0);

        // R9 recovery after re-enable
        wr(2'd0, 32'd1);
        launch(32'h0, 9);
        wait_idle("R9 restart");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule